// File: doc/BRIEF.md
# Change-Triggered Parallel-to-Serial SPI Master

This block watches a word of parallel input pins and sends it out as an SPI frame without software starting each transfer. A frame launches in one of two ways. The first is automatic: the selected data word no longer equals the last word that was shifted out. The second is a rising edge on an external trigger input. Either source can be enabled on its own. The word to send is either the pin sample or an alternate data input, chosen by a source-select input.

Configuration comes in on plain input ports:
- which of eight chip-select lines go low during a frame;
- whether those lines stay low between frames;
- which of eight attribute sets applies. Each attribute set gives a frame length and an SCK divider.

Frames go out MSB first in SPI mode 0. The block reports busy and a one-cycle done pulse. There is no receive path.

Top module: `chg_ser_master`

## Requirements
- R1: `par_i` is registered on every rising clock edge. With `src_sel_i` = 0, the word considered for launch and transmission is this registered pin sample.
- R2: With `src_sel_i` = 1, the word considered for launch and transmission is `alt_data_i`.
- R3: With `chg_en_i` = 1 and the block idle, a frame launches when the selected word differs in any bit from the compare register. Launching loads the compare register with the launched word. Reset clears it to zero. `busy_o` rises on the clock edge that launches.
- R4: With `chg_en_i` = 0, a difference between the selected word and the compare register starts no frame.
- R5: `trig_i` passes through two synchronizing flops. A rising edge seen after them launches a frame when `trig_en_i` = 1. The launch happens on the third clock edge after `trig_i` is first sampled high, and happens even if the data has not changed. With `trig_en_i` = 0, edges are ignored.
- R6: A trigger edge that arrives while a frame is in progress is held pending. It causes exactly one further frame once the current frame ends, however many edges arrived meanwhile.
- R7: `attr_sel_i` (0..7) picks attribute set k. Set k takes its length from `attr_len_i[5k+4:5k]`, clamped to 4..16 bits, and its divider D from `attr_div_i[8k+7:8k]`. Each SCK half period lasts D+1 clocks.
- R8: Frames use SPI mode 0. SCK is low when idle. MOSI carries bit len-1 of the word in the launch cycle. MOSI moves to the next lower bit at each falling SCK edge. MOSI is held steady while SCK is high. A frame lasts 2·len·(D+1) clocks.
- R9: During a frame, `cs_n_o[i]` is low exactly where bit i of the `cs_en_i` value captured at launch is 1. The chip-select lines are active low.
- R10: If `cont_i` was 1 at launch, the selected lines stay low after the frame ends, until the next launch. If it was 0, all lines return high when the frame ends.
- R11: `done_o` is high for exactly one clock, in the first cycle after the last SCK falling edge, which is the same cycle in which `busy_o` falls.
- R12: After reset, `cs_n_o` is all ones, and SCK, MOSI, busy and done are low. No trigger is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_i | input | 16 | Parallel input pins to sample |
| alt_data_i | input | 16 | Alternate data word |
| src_sel_i | input | 1 | 0: pin sample, 1: alternate word |
| chg_en_i | input | 1 | Enable launch on data change |
| trig_en_i | input | 1 | Enable launch on trigger edge |
| trig_i | input | 1 | Asynchronous trigger input |
| cont_i | input | 1 | Keep chip selects low between frames |
| attr_sel_i | input | 3 | Attribute set index |
| cs_en_i | input | 8 | Chip-select lines to assert |
| attr_len_i | input | 40 | Eight 5-bit frame lengths, set k at bits 5k+4:5k |
| attr_div_i | input | 64 | Eight 8-bit SCK dividers, set k at bits 8k+7:8k |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 8 | Chip selects, active low |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong compare register or a lost pending flag appears at the ports as a frame that is missing, extra or repeated. This shows on `busy_o` within one clock of the edge where launch should or should not occur. A wrong attribute pick, length clamp or shift order shows on SCK or MOSI at the first half period whose edge count or bit value differs. A chip-select hold error is visible on `cs_n_o` in the cycle after `busy_o` falls. The reference model runs alongside the design and flags the first cycle of divergence.

// File: rtl/chg_ser_pkg.sv
package chg_ser_pkg;
   localparam int unsigned MIN_FRAME = 4;

   typedef enum logic {
      SRC_PINS = 1'b0,
      SRC_ALT  = 1'b1
   } src_sel_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("trig_sync needs at least two stages");
   end

   logic [STAGES:0] sr_q;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sr_q[0] <= 1'b0;
            else         sr_q[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sr_q[s] <= 1'b0;
            else         sr_q[s] <= sr_q[s-1];
      end
   end

   assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/launch_ctrl.sv
module launch_ctrl #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] word_i,
   input  logic              chg_en_i,
   input  logic              trig_en_i,
   input  logic              trig_rise_i,
   input  logic              busy_i,
   output logic              launch_o,
   output logic [DATA_W-1:0] cmp_o
);
   logic [DATA_W-1:0] cmp_q;
   logic              pend_q;
   logic              chg_req;
   logic              trig_req;
   logic              trig_hit;

   assign trig_hit = trig_rise_i & trig_en_i;
   assign chg_req  = chg_en_i && (word_i != cmp_q);
   assign trig_req = trig_hit | pend_q;
   assign launch_o = !busy_i && (chg_req || trig_req);
   assign cmp_o    = cmp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q | trig_hit) & ~launch_o;
         if (launch_o) cmp_q <= word_i;
      end
   end
endmodule

// File: rtl/shift_engine.sv
module shift_engine #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEN_W  = 5,
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned NUM_CS = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              launch_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [NUM_CS-1:0] mask_i,
   input  logic              cont_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic [NUM_CS-1:0] cs_n_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int unsigned EW = LEN_W + 1;
   localparam logic [LEN_W-1:0] DW_L = LEN_W'(DATA_W);

   logic              busy_q, sck_q, done_q, cont_q;
   logic [DIV_W-1:0]  cnt_q, div_q;
   logic [EW-1:0]     edge_q;
   logic [DATA_W-1:0] sh_q;
   logic [NUM_CS-1:0] mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         cont_q <= 1'b0;
         cnt_q  <= '0;
         div_q  <= '0;
         edge_q <= '0;
         sh_q   <= '0;
         mask_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (launch_i) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            cnt_q  <= div_i;
            div_q  <= div_i;
            edge_q <= {len_i, 1'b0} - EW'(1);
            sh_q   <= word_i << (DW_L - len_i);
            mask_q <= mask_i;
            cont_q <= cont_i;
         end else if (busy_q) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - DIV_W'(1);
            end else begin
               cnt_q <= div_q;
               sck_q <= ~sck_q;
               if (sck_q) sh_q <= sh_q << 1;
               if (edge_q == '0) begin
                  busy_q <= 1'b0;
                  sck_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  edge_q <= edge_q - EW'(1);
               end
            end
         end
      end
   end

   assign sck_o  = sck_q;
   assign mosi_o = busy_q & sh_q[DATA_W-1];
   assign busy_o = busy_q;
   assign done_o = done_q;
   assign cs_n_o = ~(mask_q & {NUM_CS{busy_q | cont_q}});
endmodule

// File: rtl/chg_ser_master.sv
module chg_ser_master #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_CS      = 8,
   parameter int unsigned NUM_ATTR    = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = $clog2(NUM_ATTR),
   localparam int unsigned LEN_W      = $clog2(DATA_W + 1)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [DATA_W-1:0]         par_i,
   input  logic [DATA_W-1:0]         alt_data_i,
   input  logic                      src_sel_i,
   input  logic                      chg_en_i,
   input  logic                      trig_en_i,
   input  logic                      trig_i,
   input  logic                      cont_i,
   input  logic [SEL_W-1:0]          attr_sel_i,
   input  logic [NUM_CS-1:0]         cs_en_i,
   input  logic [NUM_ATTR*LEN_W-1:0] attr_len_i,
   input  logic [NUM_ATTR*DIV_W-1:0] attr_div_i,
   output logic                      sck_o,
   output logic                      mosi_o,
   output logic [NUM_CS-1:0]         cs_n_o,
   output logic                      busy_o,
   output logic                      done_o
);
   import chg_ser_pkg::*;

   if (DATA_W < MIN_FRAME) begin : g_bad_width
      $error("DATA_W must be at least the minimum frame length");
   end
   if (NUM_ATTR != (1 << SEL_W)) begin : g_bad_attr
      $error("NUM_ATTR must be a power of two");
   end

   logic [DATA_W-1:0] pin_q;
   logic [DATA_W-1:0] word_w;
   logic [DATA_W-1:0] cmp_w;
   logic              trig_rise;
   logic              launch;
   logic [LEN_W-1:0]  len_tab [NUM_ATTR];
   logic [DIV_W-1:0]  div_tab [NUM_ATTR];
   logic [LEN_W-1:0]  len_raw, len_c;

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pin_q <= '0;
      else         pin_q <= par_i;

   assign word_w = (src_sel_e'(src_sel_i) == SRC_ALT) ? alt_data_i : pin_q;

   for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
      assign len_tab[k] = attr_len_i[k*LEN_W +: LEN_W];
      assign div_tab[k] = attr_div_i[k*DIV_W +: DIV_W];
   end

   assign len_raw = len_tab[attr_sel_i];

   always_comb begin
      if (len_raw < LEN_W'(MIN_FRAME))   len_c = LEN_W'(MIN_FRAME);
      else if (len_raw > LEN_W'(DATA_W)) len_c = LEN_W'(DATA_W);
      else                               len_c = len_raw;
   end

   trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (trig_i),
      .rise_o (trig_rise)
   );

   launch_ctrl #(.DATA_W(DATA_W)) u_launch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .word_i      (word_w),
      .chg_en_i    (chg_en_i),
      .trig_en_i   (trig_en_i),
      .trig_rise_i (trig_rise),
      .busy_i      (busy_o),
      .launch_o    (launch),
      .cmp_o       (cmp_w)
   );

   shift_engine #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .DIV_W  (DIV_W),
      .NUM_CS (NUM_CS)
   ) u_shift (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .launch_i (launch),
      .word_i   (word_w),
      .len_i    (len_c),
      .div_i    (div_tab[attr_sel_i]),
      .mask_i   (cs_en_i),
      .cont_i   (cont_i),
      .sck_o    (sck_o),
      .mosi_o   (mosi_o),
      .cs_n_o   (cs_n_o),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );
endmodule

// File: rtl/chg_ser_master_chk.sv
module chg_ser_master_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NUM_CS = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sck_o,
   input logic              mosi_o,
   input logic [NUM_CS-1:0] cs_n_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [NUM_CS-1:0] cs_en_i,
   input logic [DATA_W-1:0] word_w,
   input logic [DATA_W-1:0] cmp_w
);
   assert_sck_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !sck_o);

   assert_mosi_steady_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && sck_o && $past(busy_o) && $past(sck_o)) |-> $stable(mosi_o));

   assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_done_at_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);

   assert_cs_from_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> ((~cs_n_o) == $past(cs_en_i)));

   assert_cmp_loaded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (cmp_w == $past(word_w)));
endmodule

bind chg_ser_master chg_ser_master_chk #(
   .DATA_W (DATA_W),
   .NUM_CS (NUM_CS)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .sck_o   (sck_o),
   .mosi_o  (mosi_o),
   .cs_n_o  (cs_n_o),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .cs_en_i (cs_en_i),
   .word_w  (word_w),
   .cmp_w   (cmp_w)
);

// File: tb/chg_ser_master_tb.sv
`timescale 1ns/1ps
module chg_ser_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] par = '0, alt = '0;
   logic        src = 1'b0, chg_en = 1'b0, trig_en = 1'b0, trig = 1'b0, cont = 1'b0;
   logic [2:0]  sel = '0;
   logic [7:0]  cs_en = '0;
   logic [39:0] attr_len = {5'd5, 5'd5, 5'd5, 5'd20, 5'd2, 5'd16, 5'd4, 5'd8};
   logic [63:0] attr_div = {8'd3, 8'd3, 8'd3, 8'd0, 8'd0, 8'd2, 8'd1, 8'd0};
   logic        sck, mosi, busy, done;
   logic [7:0]  cs_n;

   int n_cmp = 0, n_bad = 0;
   string tag = "R12";

   always #4 clk = ~clk;

   chg_ser_master u_dut (
      .clk_i(clk), .rst_ni(rst_n), .par_i(par), .alt_data_i(alt), .src_sel_i(src),
      .chg_en_i(chg_en), .trig_en_i(trig_en), .trig_i(trig), .cont_i(cont),
      .attr_sel_i(sel), .cs_en_i(cs_en), .attr_len_i(attr_len), .attr_div_i(attr_div),
      .sck_o(sck), .mosi_o(mosi), .cs_n_o(cs_n), .busy_o(busy), .done_o(done)
   );

   // behavioural reference: time since launch drives the expected waveform
   logic [15:0] m_pin, m_cmp, m_word, m_sel_word;
   logic        m_s1, m_s2, m_s3, m_pend, m_busy, m_done, m_cont, m_rise, m_launch;
   logic [7:0]  m_mask;
   int          m_t, m_len, m_div, m_raw;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pin = '0; m_cmp = '0; m_word = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_pend = 0; m_busy = 0; m_done = 0; m_cont = 0; m_mask = '0;
         m_t = 0; m_len = 4; m_div = 0;
      end else begin
         m_sel_word = src ? alt : m_pin;
         m_rise   = m_s2 && !m_s3;
         m_launch = !m_busy && ((chg_en && (m_sel_word != m_cmp)) || (m_rise && trig_en) || m_pend);
         m_pend   = (m_pend || (m_rise && trig_en)) && !m_launch;
         m_done   = 0;
         if (m_launch) begin
            m_raw  = int'(attr_len[sel*5 +: 5]);
            m_len  = (m_raw < 4) ? 4 : ((m_raw > 16) ? 16 : m_raw);
            m_div  = int'(attr_div[sel*8 +: 8]);
            m_cmp  = m_sel_word; m_word = m_sel_word;
            m_mask = cs_en; m_cont = cont; m_busy = 1; m_t = 0;
         end else if (m_busy) begin
            m_t++;
            if (m_t == 2 * m_len * (m_div + 1)) begin
               m_busy = 0; m_done = 1;
            end
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig; m_pin = par;
      end
   end

   task automatic check1(string rq, string nm, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s) %s act=%h exp=%h at %0t", rq, tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int ph;
         logic e_sck, e_mosi;
         ph     = m_t / (m_div + 1);
         e_sck  = m_busy && (ph % 2 == 1);
         e_mosi = m_busy && m_word[m_len - 1 - ph / 2];
         check1("R3", "busy", {7'd0, busy}, {7'd0, m_busy});
         check1("R7", "sck",  {7'd0, sck},  {7'd0, e_sck});
         check1("R8", "mosi", {7'd0, mosi}, {7'd0, e_mosi});
         check1("R9", "cs_n", cs_n, ~(m_mask & {8{m_busy | m_cont}}));
         check1("R11", "done", {7'd0, done}, {7'd0, m_done});
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_trig();
      trig = 1'b1; run(2); trig = 1'b0; run(2);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      run(4);
      rst_n = 1'b1;
      run(1);
      tag = "R12";  // reset state at the ports
      check1("R12", "reset cs_n", cs_n, 8'hFF);
      check1("R12", "reset busy/sck/mosi/done", {4'd0, busy, sck, mosi, done}, 8'h00);
      run(5);

      tag = "R1"; chg_en = 1; cs_en = 8'h01; sel = 3'd0; par = 16'h00A5;
      run(60); par = 16'h005A; run(60);

      tag = "R4"; chg_en = 0; par = 16'h0F0F; run(40);

      tag = "R2"; src = 1; alt = 16'hB234; chg_en = 1; sel = 3'd2; cs_en = 8'h06; run(200);

      tag = "R7"; sel = 3'd1; alt = 16'h0009; run(60);
      sel = 3'd3; alt = 16'h000C; run(40);
      sel = 3'd4; alt = 16'h8001; run(60);
      sel = 3'd5; alt = 16'h0015; run(100);

      tag = "R5"; chg_en = 0; trig_en = 0; sel = 3'd0; pulse_trig(); run(30);
      trig_en = 1; pulse_trig(); run(40);

      tag = "R6"; sel = 3'd2; pulse_trig(); pulse_trig(); pulse_trig(); run(400);

      tag = "R10"; cont = 1; cs_en = 8'hA0; sel = 3'd1; alt = 16'h0003; chg_en = 1; run(60);
      cont = 0; cs_en = 8'h11; alt = 16'h0004; run(60);
      src = 0; par = 16'h1234; sel = 3'd0; run(60);
      finish_run();
   end
endmodule